// File: doc/BRIEF.md
# Serial Configuration EEPROM Reader

This block fetches two 16-bit identification words from an external three-wire serial EEPROM. It runs by itself once reset is released, and again whenever software or a sequencer pulses `start` while the block is idle. The words are the subsystem vendor ID, held at word address 0, and the subsystem ID, held at word address 1. Each word is fetched in its own access. An access raises chip select, clocks out a start bit, a two-bit read opcode and a six-bit word address, and then clocks in sixteen data bits.

The serial wires are meant to share pins with a parallel memory bus. The serial clock is driven on the pin of address bit 1, serial data-in is driven on the pin of address bit 0, and serial data-out is read from data bit 0. Every serial timing minimum is given in nanoseconds as a parameter, alongside the system clock period. The block converts each minimum into a cycle count, rounding up, and times every edge with one shared down-counter.

The identification words are plain registered outputs. `done` marks them valid, and there is no back-pressure on them. `busy` and `done` are never high together.

Top module: `eerd_reader`

## Requirements
- R1: While reset is held, chip select, serial clock, data-in and `done` are all low.
- R2: After reset is released, the first access starts without any other input. Chip select stays low for at least 250 ns after the release.
- R3: On each serial clock rising edge the EEPROM samples data-in. Every access presents the bits 1, 1, 0 and then the 6-bit word address, MSB first. The first access of a pair uses address 0 and the second uses address 1.
- R4: Sixteen data bits follow the address, MSB first. Data-out is sampled in the last system clock of each serial clock low phase. The word from address 0 appears on `svid` and the word from address 1 appears on `ssid`.
- R5: The serial clock period is at least 1000 ns, and each high phase and each low phase lasts at least 500 ns.
- R6: Chip select rises while the serial clock is low, at least 50 ns before the first rising edge. Data-in is stable for at least 100 ns before each rising edge and for at least 20 ns after it.
- R7: Each access has exactly 25 serial clock rising edges. The serial clock is high only while chip select is high. Chip select falls together with the final falling edge. Chip select stays low for at least 250 ns between two accesses.
- R8: After both words are captured, `done` is high and `busy` is low. While `done` is high, chip select and the serial clock stay low and both ID outputs hold their values.
- R9: A `start` pulse while `done` is high begins a new pair of reads: in the next cycle `busy` is high and `done` is low. A `start` pulse while `busy` is high is ignored, so the pair still consists of exactly two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to fetch both words again; acts only while idle |
| busy | output | 1 | A read pair is in progress |
| done | output | 1 | Both words captured; the ID outputs are valid |
| svid | output | WORD_W | Subsystem vendor ID (word address 0) |
| ssid | output | WORD_W | Subsystem ID (word address 1) |
| cfg_cs | output | 1 | EEPROM chip select, active high |
| cfg_sk | output | 1 | Serial clock, shared with address bit 1 pin |
| cfg_di | output | 1 | Serial data to the EEPROM, shared with address bit 0 pin |
| cfg_do | input | 1 | Serial data from the EEPROM, read on data bit 0 |

## Verification
The hardest case to reach is a `start` pulse that arrives in the middle of an access, when every visible effect is delayed by thousands of cycles. The bench pulses `start` once during the first access and once during the second. It then counts the chip-select rising edges until `done`, and keeps counting for a while afterwards. A behavioural EEPROM in the bench records every command it decodes and timestamps every edge on the wires. It then checks the nanosecond minimums against real time rather than cycle counts, so an error in the rounding of any derived count shows up as a timing violation.

// File: rtl/eerd_pkg.sv
`timescale 1ns/1ps
package eerd_pkg;

  typedef enum logic [1:0] {
    ST_GAP  = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } eerd_state_e;

  // Start bit followed by the two-bit read opcode.
  localparam logic [2:0] READ_PREFIX = 3'b110;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eerd_timer.sv
`timescale 1ns/1ps
module eerd_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= W'(RESET_VAL);
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Every timed phase lasts exactly its loaded length.
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eerd_shift.sv
`timescale 1ns/1ps
module eerd_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par_in,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] par_out
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else if (load)
      sr_q <= par_in;
    else if (shift)
      sr_q <= {sr_q[W-2:0], ser_in};
  end

  assign par_out = sr_q;

endmodule

// File: rtl/eerd_reader.sv
`timescale 1ns/1ps
module eerd_reader
  import eerd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int SK_PERIOD_NS  = 1000,
  parameter int CS_SETUP_NS   = 50,
  parameter int DI_SETUP_NS   = 100,
  parameter int DI_HOLD_NS    = 20,
  parameter int CS_GAP_NS     = 250,
  parameter int ADDR_W        = 6,
  parameter int WORD_W        = 16,
  parameter int SVID_ADDR     = 0,
  parameter int SSID_ADDR     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] svid,
  output logic [WORD_W-1:0] ssid,
  output logic              cfg_cs,
  output logic              cfg_sk,
  output logic              cfg_di,
  input  logic              cfg_do
);

  // Cycle counts derived from the nanosecond minimums, rounded up.
  localparam int HALF_CYC = ceil_div(SK_PERIOD_NS, 2 * CLK_PERIOD_NS);
  localparam int LOW_CYC  = max2(HALF_CYC, ceil_div(DI_SETUP_NS, CLK_PERIOD_NS));
  localparam int HIGH_CYC = max2(HALF_CYC, ceil_div(DI_HOLD_NS, CLK_PERIOD_NS));
  localparam int LEAD_CYC = max2(LOW_CYC, ceil_div(CS_SETUP_NS, CLK_PERIOD_NS));
  localparam int GAP_CYC  = max2(1, ceil_div(CS_GAP_NS, CLK_PERIOD_NS));
  localparam int TMR_MAX  = max2(max2(LEAD_CYC, HIGH_CYC), GAP_CYC);
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int CMD_W    = 3 + ADDR_W;
  localparam int SLOTS    = CMD_W + WORD_W;
  localparam int IDX_W    = $clog2(SLOTS);

  localparam logic [TMR_W-1:0] LEAD_LD = TMR_W'(LEAD_CYC - 1);
  localparam logic [TMR_W-1:0] LOW_LD  = TMR_W'(LOW_CYC - 1);
  localparam logic [TMR_W-1:0] HIGH_LD = TMR_W'(HIGH_CYC - 1);
  localparam logic [TMR_W-1:0] GAP_LD  = TMR_W'(GAP_CYC - 1);

  eerd_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              word_q;
  logic              cs_q, sk_q;
  logic [WORD_W-1:0] svid_q, ssid_q;

  logic              tmr_zero, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              cmd_load, cmd_shift, dat_shift;
  logic [CMD_W-1:0]  cmd_q, cmd_word;
  logic [WORD_W-1:0] dat_q;
  logic [ADDR_W-1:0] word_addr;
  logic              last_slot;

  assign word_addr = word_q ? ADDR_W'(SSID_ADDR) : ADDR_W'(SVID_ADDR);
  assign cmd_word  = {READ_PREFIX, word_addr};
  assign last_slot = (idx_q == IDX_W'(SLOTS - 1));

  eerd_timer #(.W(TMR_W), .RESET_VAL(GAP_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  eerd_shift #(.W(CMD_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_load),
    .par_in  (cmd_word),
    .shift   (cmd_shift),
    .ser_in  (1'b0),
    .par_out (cmd_q)
  );

  eerd_shift #(.W(WORD_W)) u_dat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (1'b0),
    .par_in  ('0),
    .shift   (dat_shift),
    .ser_in  (cfg_do),
    .par_out (dat_q)
  );

  always_comb begin
    tmr_load  = 1'b0;
    tmr_val   = '0;
    cmd_load  = 1'b0;
    cmd_shift = 1'b0;
    dat_shift = 1'b0;
    unique case (state_q)
      ST_GAP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = LEAD_LD;
        cmd_load = 1'b1;
      end
      ST_LOW: if (tmr_zero) begin
        tmr_load  = 1'b1;
        tmr_val   = HIGH_LD;
        // Data-out is taken in the last cycle of the low phase.
        dat_shift = (idx_q >= IDX_W'(CMD_W));
      end
      ST_HIGH: if (tmr_zero) begin
        cmd_shift = 1'b1;
        tmr_load  = !(last_slot && word_q);
        tmr_val   = last_slot ? GAP_LD : LOW_LD;
      end
      ST_DONE: if (start) begin
        tmr_load = 1'b1;
        tmr_val  = GAP_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP;
      idx_q   <= '0;
      word_q  <= 1'b0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      svid_q  <= '0;
      ssid_q  <= '0;
    end else begin
      unique case (state_q)
        ST_GAP: if (tmr_zero) begin
          cs_q    <= 1'b1;
          idx_q   <= '0;
          state_q <= ST_LOW;
        end
        ST_LOW: if (tmr_zero) begin
          sk_q    <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tmr_zero) begin
          sk_q <= 1'b0;
          if (last_slot) begin
            cs_q <= 1'b0;
            if (word_q) begin
              ssid_q  <= dat_q;
              state_q <= ST_DONE;
            end else begin
              svid_q  <= dat_q;
              word_q  <= 1'b1;
              state_q <= ST_GAP;
            end
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_DONE: if (start) begin
          word_q  <= 1'b0;
          state_q <= ST_GAP;
        end
        default: state_q <= ST_GAP;
      endcase
    end
  end

  assign busy   = (state_q != ST_DONE);
  assign done   = (state_q == ST_DONE);
  assign svid   = svid_q;
  assign ssid   = ssid_q;
  assign cfg_cs = cs_q;
  assign cfg_sk = sk_q;
  assign cfg_di = cmd_q[CMD_W-1];

  assert_sk_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sk |-> cfg_cs);

  assert_cs_rises_sk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cs) |-> !cfg_sk);

  assert_di_steady_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sk && $past(cfg_sk)) |-> $stable(cfg_di));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cfg_cs && !cfg_sk));

  assert_ids_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(svid) && $stable(ssid)));

  assert_start_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (busy && !done));

endmodule

// File: tb/eerd_reader_bench.sv
`timescale 1ns/1ps
module eerd_reader_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, cfg_cs, cfg_sk, cfg_di, cfg_do;
  logic [15:0] svid, ssid;

  always #2.5 clk = ~clk;

  eerd_reader u_eerd_reader (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .svid   (svid),
    .ssid   (ssid),
    .cfg_cs (cfg_cs),
    .cfg_sk (cfg_sk),
    .cfg_di (cfg_di),
    .cfg_do (cfg_do)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural EEPROM with timing monitor ----------------
  logic [15:0] mem [0:63];
  logic do_r = 1'b0;
  assign cfg_do = do_r;

  int m_cnt = 0;
  logic [8:0] m_cmd = '0;
  logic [15:0] m_out = '0;
  int acc_n = 0;
  int rise_n = 0;
  int bad_rise_n = 0;
  logic [5:0] seen_addr [0:7];
  logic [2:0] seen_op [0:7];
  realtime t_cs_rise = 0, t_cs_fall = 0, t_sk_rise = 0, t_sk_fall = 0, t_di = 0;
  realtime t_rel = 0, t_first_cs = 0;
  bit have_fall = 0, have_rise = 0;
  int tv_r5 = 0, tv_r6 = 0, tv_r7 = 0;

  always @(posedge cfg_cs) begin
    if (have_fall && ($realtime - t_cs_fall) < 250.0) tv_r7++;
    if (!have_fall) t_first_cs = $realtime;
    t_cs_rise = $realtime;
    m_cnt = 0;
    rise_n = 0;
    have_rise = 0;
  end

  always @(negedge cfg_cs) begin
    if (cfg_sk !== 1'b0) tv_r7++;
    if (rise_n != 25) bad_rise_n++;
    t_cs_fall = $realtime;
    have_fall = 1;
    do_r = 1'b0;
    acc_n++;
  end

  always @(cfg_di) begin
    if (cfg_cs && have_rise && ($realtime - t_sk_rise) < 20.0) tv_r6++;
    t_di = $realtime;
  end

  always @(negedge cfg_sk) begin
    if (cfg_cs && ($realtime - t_sk_rise) < 500.0) tv_r5++;
    t_sk_fall = $realtime;
  end

  always @(posedge cfg_sk) begin
    if (!cfg_cs) tv_r7++;
    else begin
      if (($realtime - t_cs_rise) < 50.0) tv_r6++;
      if (($realtime - t_di) < 100.0) tv_r6++;
      if (have_rise && ($realtime - t_sk_rise) < 1000.0) tv_r5++;
      if (have_rise && ($realtime - t_sk_fall) < 500.0) tv_r5++;
      t_sk_rise = $realtime;
      have_rise = 1;
      rise_n++;
      if (m_cnt < 9) begin
        m_cmd = {m_cmd[7:0], cfg_di};
        m_cnt++;
        if (m_cnt == 9) begin
          if (acc_n < 8) begin
            seen_addr[acc_n] = m_cmd[5:0];
            seen_op[acc_n] = m_cmd[8:6];
          end
          m_out = mem[m_cmd[5:0]];
          #20 do_r = m_out[15];
        end
      end else begin
        m_out = {m_out[14:0], 1'b0};
        #20 do_r = m_out[15];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic clr_mon();
    acc_n = 0; bad_rise_n = 0; tv_r5 = 0; tv_r6 = 0; tv_r7 = 0;
    for (int i = 0; i < 8; i++) begin
      seen_addr[i] = 6'h3f;
      seen_op[i] = 3'b000;
    end
  endtask

  task automatic fill_mem(input logic [15:0] w0, input logic [15:0] w1);
    for (int a = 0; a < 64; a++) mem[a] = {a[5:0], 4'hC, ~a[5:0]};
    mem[0] = w0;
    mem[1] = w1;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    @(negedge clk);
    while (!done && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R8", "done reached", {31'd0, done}, 32'd1);
  endtask

  task automatic check_pair(input logic [15:0] w0, input logic [15:0] w1);
    chk(svid == w0, "R4", "svid", {16'd0, svid}, {16'd0, w0});
    chk(ssid == w1, "R4", "ssid", {16'd0, ssid}, {16'd0, w1});
    chk(seen_op[0] == 3'b110, "R3", "opcode access 0", {29'd0, seen_op[0]}, 32'h6);
    chk(seen_op[1] == 3'b110, "R3", "opcode access 1", {29'd0, seen_op[1]}, 32'h6);
    chk(seen_addr[0] == 6'd0, "R3", "address access 0", {26'd0, seen_addr[0]}, 32'h0);
    chk(seen_addr[1] == 6'd1, "R3", "address access 1", {26'd0, seen_addr[1]}, 32'h1);
    chk(acc_n == 2, "R9", "access count", acc_n, 2);
    chk(bad_rise_n == 0, "R7", "accesses without 25 edges", bad_rise_n, 0);
    chk(tv_r5 == 0, "R5", "clock period violations", tv_r5, 0);
    chk(tv_r6 == 0, "R6", "setup/hold violations", tv_r6, 0);
    chk(tv_r7 == 0, "R7", "framing violations", tv_r7, 0);
    chk(!busy, "R8", "busy low at done", {31'd0, busy}, 32'd0);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(cfg_cs == 1'b0, "R1", "cs in reset", {31'd0, cfg_cs}, 0);
    chk(cfg_sk == 1'b0, "R1", "sk in reset", {31'd0, cfg_sk}, 0);
    chk(cfg_di == 1'b0, "R1", "di in reset", {31'd0, cfg_di}, 0);
    chk(done == 1'b0, "R1", "done in reset", {31'd0, done}, 0);
  endtask

  task automatic t_autoread();
    fill_mem(16'h1234, 16'hABCD);
    clr_mon();
    t_rel = $realtime;
    rst_n = 1'b1;
    wait_done(15000);
    chk((t_first_cs - t_rel) >= 250.0, "R2", "first cs delay ns",
        int'(t_first_cs - t_rel), 250);
    check_pair(16'h1234, 16'hABCD);
  endtask

  task automatic t_hold();
    logic [15:0] s0 = svid;
    logic [15:0] s1 = ssid;
    fill_mem(16'h0F0F, 16'hF0F0);
    repeat (400) @(negedge clk);
    chk(svid == s0 && ssid == s1, "R8", "ids hold while done", {svid, ssid}, {s0, s1});
    chk(!cfg_cs && !cfg_sk, "R8", "wires quiet while done", {30'd0, cfg_cs, cfg_sk}, 0);
    chk(acc_n == 2, "R8", "no access while done", acc_n, 2);
  endtask

  task automatic t_restart(input logic [15:0] w0, input logic [15:0] w1);
    fill_mem(w0, w1);
    clr_mon();
    pulse_start();
    chk(busy && !done, "R9", "busy after start", {30'd0, busy, done}, 32'h2);
    wait_done(15000);
    check_pair(w0, w1);
  endtask

  task automatic t_start_busy();
    fill_mem(16'hA5A5, 16'h5A5A);
    clr_mon();
    pulse_start();
    repeat (3000) @(negedge clk);
    pulse_start();
    repeat (5000) @(negedge clk);
    pulse_start();
    wait_done(15000);
    check_pair(16'hA5A5, 16'h5A5A);
    repeat (2000) @(negedge clk);
    chk(acc_n == 2 && done, "R9", "start while busy ignored", acc_n, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_autoread();
    t_hold();
    t_restart(16'hFFFF, 16'h0000);
    t_restart(16'h0000, 16'hFFFF);
    t_restart(16'h8001, 16'h7FFE);
    t_start_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule